// File: doc/BRIEF.md
# Serial ADC Register Interface

This block is the device-side serial front end of a sigma-delta converter. A host clocks bytes in on a serial data line while an active-low select is held low. The first byte of every access goes to a routing register. Its fields choose the register that the next transfer reads or writes: routing, setup, calibration or result. The gain and standby fields of that byte take effect as soon as it is accepted. When the transfer completes, the block waits for a new routing byte.

The conversion path outside this block delivers 16-bit results on a parallel port with a one-cycle update strobe. The block holds the latest accepted result and shifts it out MSB first when the host asks for it. An active-low ready output signals that an unread result is waiting. Ready returns high when the full result has been shifted out. It also returns high a fixed number of master-clock cycles before the next expected update, so that a read cannot straddle a register refresh. A filter-hold bit in the setup register blocks result updates while it is set. After the bit is cleared, the first two updates are dropped.

The serial pins are synchronised to the master clock and sampled there. The host therefore has to run its serial clock well below the master clock.

Top module: `sadc_serial_regs`

## Requirements
- R1: After reset, ready is high, serial out is high, setup holds 0x08, calibration holds 0, gain is 0 and standby is 0.
- R2: A routing byte whose bit 7 is 1 is dropped. It changes neither gain nor standby, and the next byte is again taken as a routing byte.
- R3: Routing byte fields: bits 5:4 select the register (00 routing, 01 setup, 10 calibration, 11 result), bit 3 = 1 means read, bit 2 is standby and bits 1:0 are gain. Bit 2 and bits 1:0 drive the standby and gain outputs as soon as the byte is accepted.
- R4: A setup write (0x10) takes the next 8 bits, which then appear on the setup output. A setup read (0x18) returns them.
- R5: A calibration write (0x20) takes the next CAL_W bits, which appear on the calibration output. A calibration read (0x28) returns them.
- R6: A result read (0x38) shifts out the 16-bit result MSB first. The host samples each bit on the rising serial edge, and the output changes on the falling edge. Ready is high after the 16th bit.
- R7: A result write (0x30) takes 16 bits and discards them. The stored result is unchanged, and the next byte is a routing byte.
- R8: An accepted update stores the word and drives ready low on the next master-clock edge.
- R9: If no read happens, ready goes high PERIOD-BLANK master-clock cycles after the last update strobe. The stored word stays readable.
- R10: While setup bit 0 (filter hold) is 1, updates are ignored and ready is not forced high. After the bit clears, the first two updates are dropped and the third is stored.
- R11: A routing read (routing field 00, bit 3 = 1) returns 8 bits: the current ready level followed by bits 6:0 of that same routing byte.
- R12: Serial clock edges while select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high when not reading |
| rdy_n | output | 1 | Active-low result-ready |
| upd_valid | input | 1 | One-cycle update strobe from the conversion path |
| upd_word | input | 16 | Conversion result presented with the strobe |
| setup_q | output | 8 | Setup register contents |
| cal_q | output | CAL_W | Calibration register contents |
| gain | output | 2 | Gain select from the last routing byte |
| standby | output | 1 | Standby request from the last routing byte |

## Verification
The hardest state to reach is the filter-hold recovery. It needs an unread result already waiting, a setup write that raises hold while ready is low, an update that must be ignored, and then a second setup write that clears hold, followed by exactly three updates. The stimulus builds this in order and reads the result register at two points. The first read shows that the held update was ignored. The second shows that only the third update after release was stored. The ready-timeout case is reached by stopping all reads and strobes and then probing ready on either side of the PERIOD-BLANK boundary.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {PH_COMM, PH_WRITE, PH_READ} phase_t;

  localparam logic [1:0] RS_COMM  = 2'b00;
  localparam logic [1:0] RS_SETUP = 2'b01;
  localparam logic [1:0] RS_CAL   = 2'b10;
  localparam logic [1:0] RS_DATA  = 2'b11;

  // A routing byte is taken only when its top bit is clear.
  function automatic logic comm_accept(input logic [7:0] b);
    return ~b[7];
  endfunction

  // Length in bits of the transfer that follows a routing byte.
  function automatic int unsigned reg_bits(input logic [1:0] rs, input int unsigned cal_w);
    case (rs)
      RS_CAL:  return cal_w;
      RS_DATA: return 16;
      default: return 8;
    endcase
  endfunction

  // Age since the last update at which ready is withdrawn.
  function automatic int unsigned blank_start(input int unsigned period, input int unsigned blank);
    return (period > blank) ? period - blank : 0;
  endfunction

endpackage

// File: rtl/sadc_pin_sync.sv
module sadc_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic din
);
  logic [2:0] m1, m2;
  logic       sck_d;
  logic       sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1    <= 3'b110;
      m2    <= 3'b110;
      sck_d <= 1'b1;
    end else begin
      m1    <= {sck, cs_n, sdi};
      m2    <= m1;
      sck_d <= m2[2];
    end
  end

  assign sel  = ~m2[1];
  assign rise = sel & m2[2] & ~sck_d;
  assign fall = sel & ~m2[2] & sck_d;
  assign din  = m2[0];
endmodule

// File: rtl/sadc_serial_ctrl.sv
module sadc_serial_ctrl
  import sadc_pkg::*;
#(
  parameter int unsigned CAL_W = 24,
  parameter int unsigned SH_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             din,
  input  logic             rdy_n,
  input  logic [15:0]      data_q,
  output logic             sdo,
  output logic [7:0]       setup_q,
  output logic [CAL_W-1:0] cal_q,
  output logic [1:0]       gain,
  output logic             standby,
  output logic             read_done
);
  localparam int unsigned CW        = $clog2(SH_W + 1);
  localparam logic [7:0]  SETUP_RST = 8'h08;

  phase_t          phase;
  logic [CW-1:0]   cnt, len;
  logic [SH_W-1:0] shreg, wv, rd_al;
  logic [1:0]      rs_q;
  logic [7:0]      nb;
  logic            last;

  assign nb        = {shreg[6:0], din};
  assign wv        = {shreg[SH_W-2:0], din};
  assign last      = (cnt == len - CW'(1));
  assign read_done = rise && (phase == PH_READ) && last && (rs_q == RS_DATA);

  // Read value, left aligned in the shifter, chosen by the incoming routing byte.
  always_comb begin
    rd_al = '0;
    case (nb[5:4])
      RS_COMM:  rd_al[SH_W-1 -: 8]     = {rdy_n, nb[6:0]};
      RS_SETUP: rd_al[SH_W-1 -: 8]     = setup_q;
      RS_CAL:   rd_al[SH_W-1 -: CAL_W] = cal_q;
      default:  rd_al[SH_W-1 -: 16]    = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_COMM;
      cnt     <= '0;
      len     <= CW'(8);
      shreg   <= '0;
      rs_q    <= RS_COMM;
      sdo     <= 1'b1;
      setup_q <= SETUP_RST;
      cal_q   <= '0;
      gain    <= '0;
      standby <= 1'b0;
    end else if (rise) begin
      case (phase)
        PH_COMM: begin
          shreg <= wv;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            if (comm_accept(nb)) begin
              rs_q    <= nb[5:4];
              standby <= nb[2];
              gain    <= nb[1:0];
              len     <= CW'(reg_bits(nb[5:4], CAL_W));
              if (nb[3]) begin
                phase <= PH_READ;
                shreg <= rd_al;
                sdo   <= rd_al[SH_W-1];
              end else if (nb[5:4] != RS_COMM) begin
                phase <= PH_WRITE;
              end
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_WRITE: begin
          shreg <= wv;
          if (last) begin
            cnt   <= '0;
            phase <= PH_COMM;
            if (rs_q == RS_SETUP)    setup_q <= wv[7:0];
            else if (rs_q == RS_CAL) cal_q   <= wv[CAL_W-1:0];
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_READ: begin
          shreg <= shreg << 1;
          if (last) begin
            cnt   <= '0;
            phase <= PH_COMM;
            sdo   <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: phase <= PH_COMM;
      endcase
    end else if (fall && phase == PH_READ) begin
      sdo <= shreg[SH_W-1];
    end
  end
endmodule

// File: rtl/sadc_ready_timer.sv
module sadc_ready_timer
  import sadc_pkg::*;
#(
  parameter int unsigned PERIOD = 2000,
  parameter int unsigned BLANK  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_valid,
  input  logic [15:0] upd_word,
  input  logic        fsync,
  input  logic        read_done,
  output logic [15:0] data_q,
  output logic        rdy_n,
  output logic        load,
  output logic        blank
);
  localparam int unsigned TW       = $clog2(PERIOD + 1);
  localparam logic [TW-1:0] AGE_MAX  = TW'(PERIOD);
  localparam logic [TW-1:0] BLANK_AT = TW'(blank_start(PERIOD, BLANK));

  logic [TW-1:0] age;
  logic [1:0]    skip;

  assign load  = upd_valid && !fsync && (skip == 2'd0);
  assign blank = (age >= BLANK_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= '0;
      skip   <= '0;
      data_q <= '0;
      rdy_n  <= 1'b1;
    end else begin
      if (upd_valid)            age <= '0;
      else if (age != AGE_MAX)  age <= age + TW'(1);

      if (fsync)                          skip <= 2'd2;
      else if (upd_valid && skip != 2'd0) skip <= skip - 2'd1;

      if (load) data_q <= upd_word;

      if (load)                    rdy_n <= 1'b0;
      else if (read_done || blank) rdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/sadc_serial_regs.sv
module sadc_serial_regs #(
  parameter int unsigned CAL_W  = 24,
  parameter int unsigned PERIOD = 2000,
  parameter int unsigned BLANK  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  output logic             rdy_n,
  input  logic             upd_valid,
  input  logic [15:0]      upd_word,
  output logic [7:0]       setup_q,
  output logic [CAL_W-1:0] cal_q,
  output logic [1:0]       gain,
  output logic             standby
);
  localparam int unsigned SH_W = (CAL_W > 16) ? CAL_W : 16;

  logic        s_rise, s_fall, s_din;
  logic        read_done, upd_load, blank_win, fsync;
  logic [15:0] data_q;

  assign fsync = setup_q[0];

  sadc_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .rise(s_rise), .fall(s_fall), .din(s_din)
  );

  sadc_serial_ctrl #(.CAL_W(CAL_W), .SH_W(SH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rise(s_rise), .fall(s_fall), .din(s_din),
    .rdy_n(rdy_n), .data_q(data_q), .sdo(sdo), .setup_q(setup_q),
    .cal_q(cal_q), .gain(gain), .standby(standby), .read_done(read_done)
  );

  sadc_ready_timer #(.PERIOD(PERIOD), .BLANK(BLANK)) u_rdy (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_word(upd_word),
    .fsync(fsync), .read_done(read_done), .data_q(data_q), .rdy_n(rdy_n),
    .load(upd_load), .blank(blank_win)
  );
endmodule

// File: rtl/sadc_serial_regs_chk.sv
module sadc_serial_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic rdy_n,
  input logic read_done,
  input logic blank,
  input logic fsync
);
  // R8: a stored update makes ready active on the next edge
  a_r8_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !rdy_n);

  // R8: ready only falls because of a stored update
  a_r8_fall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(load));

  // R6: finishing a result read withdraws ready
  a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !load) |=> rdy_n);

  // R9: inside the blanking window ready is withdrawn
  a_r9_blank_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !load) |=> rdy_n);

  // R10: no update is stored while filter hold is set
  a_r10_hold_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> !load);
endmodule

bind sadc_serial_regs sadc_serial_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(upd_load), .rdy_n(rdy_n),
  .read_done(read_done), .blank(blank_win), .fsync(fsync)
);

// File: tb/sadc_serial_regs_test.sv
module sadc_serial_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b1;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b1;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_word = '0;
  logic        sdo, rdy_n, standby;
  logic [7:0]  setup_q;
  logic [23:0] cal_q;
  logic [1:0]  gain;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_val[$];
  string       exp_tag[$];
  logic [31:0] got_val[$];

  always #10 clk = ~clk;

  sadc_serial_regs uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .rdy_n(rdy_n), .upd_valid(upd_valid), .upd_word(upd_word),
    .setup_q(setup_q), .cal_q(cal_q), .gain(gain), .standby(standby)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Host serial model: data set after the falling edge, sdo sampled before the rising edge.
  task automatic xfer(input int n, input logic [31:0] wv, output logic [31:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sck = 1'b0;
      sdi = wv[i];
      repeat (6) @(negedge clk);
      rv[i] = sdo;
      sck = 1'b1;
      repeat (5) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] cmd, input int n, input logic [31:0] val);
    logic [31:0] rv;
    xfer(8, {24'h0, cmd}, rv);
    if (n > 0) xfer(n, val, rv);
  endtask

  // Driver side of the scoreboard: expected item queued, captured item queued.
  task automatic rd(input logic [7:0] cmd, input int n, input logic [31:0] exp, input string tag);
    logic [31:0] rv;
    exp_val.push_back(exp);
    exp_tag.push_back(tag);
    xfer(8, {24'h0, cmd}, rv);
    xfer(n, 32'h0, rv);
    got_val.push_back(rv);
  endtask

  task automatic strobe(input logic [15:0] w);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_word  = w;
    @(negedge clk);
    upd_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (got_val.size() > 0 && exp_val.size() > 0)
        check(exp_tag.pop_front(), got_val.pop_front(), exp_val.pop_front());
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdy_n", {31'h0, rdy_n}, 32'h1);
    check("R1 sdo", {31'h0, sdo}, 32'h1);
    check("R1 setup", {24'h0, setup_q}, 32'h08);
    check("R1 cal", {8'h0, cal_q}, 32'h0);
    check("R1 gain", {30'h0, gain}, 32'h0);
    check("R1 standby", {31'h0, standby}, 32'h0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // R4 setup write and read back
    wr(8'h10, 8, 32'h66);
    check("R4 setup out", {24'h0, setup_q}, 32'h66);
    rd(8'h18, 8, 32'h66, "R4 setup readback");

    // R2 rejected routing byte (would set standby and gain if taken)
    wr(8'hFF, 0, 32'h0);
    check("R2 standby unchanged", {31'h0, standby}, 32'h0);
    check("R2 gain unchanged", {30'h0, gain}, 32'h0);
    wr(8'h10, 8, 32'h3C);
    check("R2 still routing", {24'h0, setup_q}, 32'h3C);

    // R5 calibration
    wr(8'h20, 24, 32'hC0FFEE);
    check("R5 cal out", {8'h0, cal_q}, 32'hC0FFEE);
    rd(8'h28, 24, 32'hC0FFEE, "R5 cal readback");

    // R8 and R6 result path
    strobe(16'hA5C3);
    check("R8 ready low", {31'h0, rdy_n}, 32'h0);
    rd(8'h38, 16, 32'hA5C3, "R6 result read");
    check("R6 ready high after read", {31'h0, rdy_n}, 32'h1);

    // R7 result write is discarded
    strobe(16'h1111);
    wr(8'h30, 16, 32'hBEEF);
    rd(8'h38, 16, 32'h1111, "R7 result kept");

    // R11 routing read, R3 gain field
    rd(8'h0B, 8, 32'h8B, "R11 routing read");
    check("R3 gain from routing", {30'h0, gain}, 32'h3);
    wr(8'h04, 0, 32'h0);
    check("R3 standby set", {31'h0, standby}, 32'h1);
    check("R3 gain cleared", {30'h0, gain}, 32'h0);
    wr(8'h00, 0, 32'h0);
    check("R3 standby clear", {31'h0, standby}, 32'h0);

    // R12 clocks with select high are ignored
    cs_n = 1'b1;
    wr(8'h10, 8, 32'hAA);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 setup unchanged", {24'h0, setup_q}, 32'h3C);
    rd(8'h18, 8, 32'h3C, "R12 routing intact");

    // R9 ready withdrawn before the next update
    strobe(16'h2222);
    repeat (1400) @(negedge clk);
    check("R9 ready before window", {31'h0, rdy_n}, 32'h0);
    repeat (200) @(negedge clk);
    check("R9 ready after window", {31'h0, rdy_n}, 32'h1);
    rd(8'h38, 16, 32'h2222, "R9 word still readable");

    // R10 filter hold
    strobe(16'h3333);
    wr(8'h10, 8, 32'h3D);
    check("R10 hold keeps ready low", {31'h0, rdy_n}, 32'h0);
    strobe(16'h4444);
    rd(8'h38, 16, 32'h3333, "R10 update ignored in hold");
    wr(8'h10, 8, 32'h3C);
    strobe(16'h5555);
    strobe(16'h6666);
    check("R10 two dropped after release", {31'h0, rdy_n}, 32'h1);
    strobe(16'h7777);
    check("R10 third stored", {31'h0, rdy_n}, 32'h0);
    rd(8'h38, 16, 32'h7777, "R10 third word");

    while (exp_val.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule